// File: doc/BRIEF.md
# Bus Protection Step Sequencer

This block fences or unfences the bus masters of one power domain by working through a short table of protection steps. Each step picks one of two register banks (infrastructure configuration or memory interconnect), carries a mask and an acknowledge mask for release, and names the registers to touch. A step can either write its mask to a dedicated set or release register, or update a shared enable register by read, modify and write.

After each write the block polls the step's status register at a fixed interval until the acknowledge condition holds. It gives up on the step once a cycle budget is spent. A fence command walks the table from the first entry upward. A release command walks it from the last entry down. The block ends every operation with one of three single-cycle result pulses: done, timeout or bad target.

The table is presented on input ports by the surrounding power controller and must stay stable while the block is busy. Register accesses go out on a simple internal port. Read data is returned one cycle after a read request.

Top module: `busprot_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `timeout`, `bad_tgt` and `reg_req` are all low.
- R2: In idle, a high `cmd_fence` or `cmd_release` starts an operation and `busy` is high from the next cycle. When both are high, fence wins. Commands that arrive while `busy` is high are ignored and cause no register access.
- R3: A fence visits steps 0, 1, 2 and so on upward. It finishes with `done` at the first step whose mask is zero, or after the last step.
- R4: A release visits steps from the last one down to step 0. Steps whose mask is zero are skipped and the walk continues, ending with `done` after step 0.
- R5: For a fence step, a nonzero set offset produces one write of the mask to that offset. A zero set offset produces a read of the enable offset followed by a write to it of the read value OR the mask.
- R6: For a release step, a nonzero release offset produces one write of the mask to that offset. A zero release offset produces a read of the enable offset followed by a write to it of the read value with the mask bits cleared.
- R7: A fence step is acknowledged when every mask bit reads 1 at the status offset. A release step is acknowledged when every release-acknowledge bit reads 0 there.
- R8: A step's bank code 0 drives `reg_bank` low and code 1 drives it high. Codes 2 and 3 end the operation with `bad_tgt` before that step issues any access.
- R9: Status reads for one step are `GAP_CYC+2` cycles apart. If a step is still unacknowledged at a status check made `TMO_CYC` or more cycles after its first status read, the operation ends with `timeout` and later steps are not visited.
- R10: Each operation ends with exactly one of `done`, `timeout` and `bad_tgt`, high for one cycle, in the same cycle in which `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_fence | input | 1 | Start a fence (forward) operation |
| cmd_release | input | 1 | Start a release (reverse) operation |
| tbl_bank | input | STEPS*2 | Per-step bank code |
| tbl_set_ofs | input | STEPS*AW | Per-step dedicated set register offset, 0 = none |
| tbl_rel_ofs | input | STEPS*AW | Per-step dedicated release register offset, 0 = none |
| tbl_en_ofs | input | STEPS*AW | Per-step enable register offset |
| tbl_sta_ofs | input | STEPS*AW | Per-step status register offset |
| tbl_mask | input | STEPS*DW | Per-step protection mask, 0 = empty step |
| tbl_rel_ack | input | STEPS*DW | Per-step acknowledge mask for release |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished with all steps acknowledged |
| timeout | output | 1 | Operation aborted on an unacknowledged step |
| bad_tgt | output | 1 | Operation aborted on an unknown bank code |
| reg_req | output | 1 | Register access request |
| reg_wr | output | 1 | Access is a write |
| reg_bank | output | 1 | Bank select, 0 infrastructure, 1 interconnect |
| reg_addr | output | AW | Register offset |
| reg_wdata | output | DW | Write data |
| reg_rdata | input | DW | Read data, valid the cycle after a read request |

## Verification
The assertions watch the handshake on every cycle. A command from idle always raises `busy`. `busy` only falls together with a result pulse, the three pulses never overlap, and the register port stays silent while idle. The walk order, skipping of empty steps, the choice between direct and read-modify-write access, the acknowledge conditions, the poll spacing, the timeout count and the rejection of bad bank codes depend on table contents and bank responses. These can only be shown by the bench's scenarios, which compare every register write against a behavioural model of the banks.

// File: rtl/busprot_pkg.sv
// Shared types for the bus protection step sequencer.
package busprot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_WR_DIRECT,
        ST_RD_EN,
        ST_MODIFY,
        ST_POLL_RD,
        ST_EVAL,
        ST_GAP
    } seq_state_t;

    typedef enum logic [1:0] {
        RES_NONE,
        RES_DONE,
        RES_TMO,
        RES_BAD
    } seq_result_t;

    localparam logic [1:0] BANK_INFRA = 2'd0;
    localparam logic [1:0] BANK_ICON  = 2'd1;

endpackage

// File: rtl/busprot_step_walker.sv
// Step index keeper.
// Holds the current table index and the walk direction. On start it
// points at step 0 for a fence or at the last step for a release, and
// each advance moves one step in that direction.
// Assumes STEPS >= 2 and that advance is never raised at the end step.
module busprot_step_walker #(
    parameter int STEPS = 4,
    localparam int IW = $clog2(STEPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_fence,
    input  logic          advance,
    output logic [IW-1:0] idx,
    output logic          fence_op,
    output logic          at_end
);

    localparam logic [IW-1:0] LAST = IW'(STEPS - 1);

    // Index and direction register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            fence_op <= 1'b0;
        end else if (start) begin
            idx      <= start_fence ? '0 : LAST;
            fence_op <= start_fence;
        end else if (advance) begin
            idx      <= fence_op ? idx + 1'b1 : idx - 1'b1;
        end
    end

    // Last step in the current direction.
    always_comb at_end = fence_op ? (idx == LAST) : (idx == '0);

endmodule

// File: rtl/busprot_poll_timer.sv
// Poll interval and step timeout counters.
// The gap counter stretches the wait between status reads to GAP_CYC
// cycles. The elapsed counter starts from zero at the write that opens
// a step and saturates at TMO_CYC.
// Assumes GAP_CYC >= 1 and TMO_CYC >= 1.
module busprot_poll_timer #(
    parameter int GAP_CYC = 1000,
    parameter int TMO_CYC = 100_000_000,
    localparam int GW = $clog2(GAP_CYC + 1),
    localparam int EW = $clog2(TMO_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic running,
    input  logic gap_load,
    output logic gap_over,
    output logic expired
);

    localparam logic [GW-1:0] GAP_RELOAD = GW'(GAP_CYC - 1);
    localparam logic [EW-1:0] TMO_LIMIT  = EW'(TMO_CYC);

    logic [GW-1:0] gap_cnt;
    logic [EW-1:0] elapsed;

    // Countdown for the wait between polls.
    always_ff @(posedge clk) begin
        if (!rst_n)                gap_cnt <= '0;
        else if (gap_load)         gap_cnt <= GAP_RELOAD;
        else if (gap_cnt != '0)    gap_cnt <= gap_cnt - 1'b1;
    end

    // Saturating cycle count since the step's first status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                                elapsed <= '0;
        else if (restart)                          elapsed <= '0;
        else if (running && elapsed < TMO_LIMIT)   elapsed <= elapsed + 1'b1;
    end

    always_comb gap_over = (gap_cnt == '0);
    always_comb expired  = (elapsed >= TMO_LIMIT);

endmodule

// File: rtl/busprot_sequencer.sv
// Bus protection step sequencer, top level.
// Walks a table of protection steps and, for each, issues a direct
// write or a read-modify-write of an enable register, then polls a
// status register until it is acknowledged or a timeout expires.
// Assumes the table ports are stable while busy, and that reg_rdata
// holds the read result in the cycle after a read request.
module busprot_sequencer
    import busprot_pkg::*;
#(
    parameter int STEPS   = 4,
    parameter int AW      = 8,
    parameter int DW      = 32,
    parameter int GAP_CYC = 1000,
    parameter int TMO_CYC = 100_000_000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_fence,
    input  logic                     cmd_release,
    input  logic [STEPS-1:0][1:0]    tbl_bank,
    input  logic [STEPS-1:0][AW-1:0] tbl_set_ofs,
    input  logic [STEPS-1:0][AW-1:0] tbl_rel_ofs,
    input  logic [STEPS-1:0][AW-1:0] tbl_en_ofs,
    input  logic [STEPS-1:0][AW-1:0] tbl_sta_ofs,
    input  logic [STEPS-1:0][DW-1:0] tbl_mask,
    input  logic [STEPS-1:0][DW-1:0] tbl_rel_ack,
    output logic                     busy,
    output logic                     done,
    output logic                     timeout,
    output logic                     bad_tgt,
    output logic                     reg_req,
    output logic                     reg_wr,
    output logic                     reg_bank,
    output logic [AW-1:0]            reg_addr,
    output logic [DW-1:0]            reg_wdata,
    input  logic [DW-1:0]            reg_rdata
);

    localparam int IW = $clog2(STEPS);

    seq_state_t  state, nxt;
    seq_result_t fin;
    logic [IW-1:0] idx;
    logic fence_op, at_end;
    logic w_start, w_adv;
    logic t_restart, t_gap, t_run, gap_over, expired;
    logic [1:0]    cur_bank;
    logic [AW-1:0] cur_dir_ofs;
    logic [DW-1:0] cur_mask, cur_ack;
    logic          acked;

    busprot_step_walker #(.STEPS(STEPS)) i_walker (
        .clk(clk), .rst_n(rst_n),
        .start(w_start), .start_fence(cmd_fence), .advance(w_adv),
        .idx(idx), .fence_op(fence_op), .at_end(at_end)
    );

    busprot_poll_timer #(.GAP_CYC(GAP_CYC), .TMO_CYC(TMO_CYC)) i_timer (
        .clk(clk), .rst_n(rst_n),
        .restart(t_restart), .running(t_run), .gap_load(t_gap),
        .gap_over(gap_over), .expired(expired)
    );

    // Fields of the step under the walker.
    always_comb begin
        cur_bank    = tbl_bank[idx];
        cur_mask    = tbl_mask[idx];
        cur_ack     = tbl_rel_ack[idx];
        cur_dir_ofs = fence_op ? tbl_set_ofs[idx] : tbl_rel_ofs[idx];
    end

    // Acknowledge test on the status word returned this cycle.
    always_comb acked = fence_op ? ((reg_rdata & cur_mask) == cur_mask)
                                 : ((reg_rdata & cur_ack) == '0);

    always_comb t_run = (state == ST_POLL_RD) || (state == ST_EVAL) || (state == ST_GAP);

    // Next state, register port drive and result selection.
    always_comb begin
        nxt       = state;
        fin       = RES_NONE;
        w_start   = 1'b0;
        w_adv     = 1'b0;
        t_restart = 1'b0;
        t_gap     = 1'b0;
        reg_req   = 1'b0;
        reg_wr    = 1'b0;
        reg_addr  = '0;
        reg_wdata = '0;
        case (state)
            ST_IDLE: begin
                if (cmd_fence || cmd_release) begin
                    w_start = 1'b1;
                    nxt     = ST_PICK;
                end
            end
            ST_PICK: begin
                if (cur_mask == '0) begin
                    if (fence_op || at_end) begin
                        fin = RES_DONE;
                        nxt = ST_IDLE;
                    end else begin
                        w_adv = 1'b1;
                    end
                end else if (cur_bank != BANK_INFRA && cur_bank != BANK_ICON) begin
                    fin = RES_BAD;
                    nxt = ST_IDLE;
                end else if (cur_dir_ofs != '0) begin
                    nxt = ST_WR_DIRECT;
                end else begin
                    nxt = ST_RD_EN;
                end
            end
            ST_WR_DIRECT: begin
                reg_req   = 1'b1;
                reg_wr    = 1'b1;
                reg_addr  = cur_dir_ofs;
                reg_wdata = cur_mask;
                t_restart = 1'b1;
                nxt       = ST_POLL_RD;
            end
            ST_RD_EN: begin
                reg_req  = 1'b1;
                reg_addr = tbl_en_ofs[idx];
                nxt      = ST_MODIFY;
            end
            ST_MODIFY: begin
                reg_req   = 1'b1;
                reg_wr    = 1'b1;
                reg_addr  = tbl_en_ofs[idx];
                reg_wdata = fence_op ? (reg_rdata | cur_mask) : (reg_rdata & ~cur_mask);
                t_restart = 1'b1;
                nxt       = ST_POLL_RD;
            end
            ST_POLL_RD: begin
                reg_req  = 1'b1;
                reg_addr = tbl_sta_ofs[idx];
                nxt      = ST_EVAL;
            end
            ST_EVAL: begin
                if (acked) begin
                    if (at_end) begin
                        fin = RES_DONE;
                        nxt = ST_IDLE;
                    end else begin
                        w_adv = 1'b1;
                        nxt   = ST_PICK;
                    end
                end else if (expired) begin
                    fin = RES_TMO;
                    nxt = ST_IDLE;
                end else begin
                    t_gap = 1'b1;
                    nxt   = ST_GAP;
                end
            end
            ST_GAP: begin
                if (gap_over) nxt = ST_POLL_RD;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb reg_bank = cur_bank[0];
    always_comb busy     = (state != ST_IDLE);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // One-cycle result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            timeout <= 1'b0;
            bad_tgt <= 1'b0;
        end else begin
            done    <= (fin == RES_DONE);
            timeout <= (fin == RES_TMO);
            bad_tgt <= (fin == RES_BAD);
        end
    end

endmodule

// File: rtl/busprot_sequencer_chk.sv
// Handshake checker for the bus protection step sequencer.
// Observes the top-level ports only.
module busprot_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_fence,
    input logic cmd_release,
    input logic busy,
    input logic done,
    input logic timeout,
    input logic bad_tgt,
    input logic reg_req
);

    // R10: never more than one result at a time.
    a_r10_single_result: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, timeout, bad_tgt}));

    // R10: a result pulse comes exactly as busy drops.
    a_r10_result_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (done || timeout || bad_tgt) |-> (!busy && $past(busy)));

    // R10: busy never drops without a result.
    a_r10_busy_fall_reported: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || timeout || bad_tgt));

    // R2: a command seen in idle starts an operation.
    a_r2_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (cmd_fence || cmd_release)) |=> busy);

    // R1: the register port is silent while idle.
    a_r1_idle_port_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !reg_req);

endmodule

bind busprot_sequencer busprot_sequencer_chk i_chk (
    .clk(clk), .rst_n(rst_n), .cmd_fence(cmd_fence), .cmd_release(cmd_release),
    .busy(busy), .done(done), .timeout(timeout), .bad_tgt(bad_tgt),
    .reg_req(reg_req)
);

// File: tb/test_busprot_sequencer.sv
// Bench: behavioural banks plus a model that predicts every register
// write and the result of each operation, compared on every clock.
module test_busprot_sequencer;

    localparam int STEPS = 4;
    localparam int AW    = 8;
    localparam int DW    = 32;
    localparam int GAP   = 3;
    localparam int TMO   = 40;
    // Bench register layout inside each bank.
    localparam logic [AW-1:0] O_SET = 8'd1, O_REL = 8'd2, O_EN = 8'd3, O_STA = 8'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_fence = 1'b0, cmd_release = 1'b0;
    logic [STEPS-1:0][1:0]    t_bank;
    logic [STEPS-1:0][AW-1:0] t_set, t_rel, t_en, t_sta;
    logic [STEPS-1:0][DW-1:0] t_mask, t_ack;
    logic busy, done, timeout, bad_tgt;
    logic reg_req, reg_wr, reg_bank;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] reg_wdata;
    logic [DW-1:0] reg_rdata = '0;

    always #5 clk = ~clk;

    busprot_sequencer #(.STEPS(STEPS), .AW(AW), .DW(DW), .GAP_CYC(GAP), .TMO_CYC(TMO))
    i_busprot_sequencer (
        .clk(clk), .rst_n(rst_n), .cmd_fence(cmd_fence), .cmd_release(cmd_release),
        .tbl_bank(t_bank), .tbl_set_ofs(t_set), .tbl_rel_ofs(t_rel),
        .tbl_en_ofs(t_en), .tbl_sta_ofs(t_sta), .tbl_mask(t_mask), .tbl_rel_ack(t_ack),
        .busy(busy), .done(done), .timeout(timeout), .bad_tgt(bad_tgt),
        .reg_req(reg_req), .reg_wr(reg_wr), .reg_bank(reg_bank),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Behavioural banks: one protect register per bank, status = protect
    // register with forced-high and forced-low bits.
    logic [DW-1:0] bank_en [2];
    logic [DW-1:0] hi_f [2];
    logic [DW-1:0] lo_f [2];
    logic          bank_wipe = 1'b0;

    always @(posedge clk) begin
        if (bank_wipe) begin
            bank_en[0] <= '0;
            bank_en[1] <= '0;
        end else if (reg_req && reg_wr) begin
            case (reg_addr)
                O_SET:   bank_en[reg_bank] <= bank_en[reg_bank] | reg_wdata;
                O_REL:   bank_en[reg_bank] <= bank_en[reg_bank] & ~reg_wdata;
                O_EN:    bank_en[reg_bank] <= reg_wdata;
                default: ;
            endcase
        end
        if (reg_req && !reg_wr)
            reg_rdata <= (reg_addr == O_EN)  ? bank_en[reg_bank] :
                         (reg_addr == O_STA) ? ((bank_en[reg_bank] | hi_f[reg_bank]) & ~lo_f[reg_bank]) :
                         '0;
    end

    // Reference model state.
    logic [DW-1:0] mdl_en [2];
    logic [AW+DW:0] exp_q [$];
    int checks = 0, fails = 0;
    int cyc = 0;
    string cur_tag = "R1";
    bit finished = 1'b0;
    int sta_reads = 0, last_read = -1;
    bit track_reads = 1'b0;
    int track_bank = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison of register port activity against the model.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && reg_req && reg_wr) begin
            logic [AW+DW:0] got;
            got = {reg_bank, reg_addr, reg_wdata};
            if (exp_q.size() == 0) begin
                check(1'b0, cur_tag, "unexpected write", got, 0);
            end else begin
                logic [AW+DW:0] e;
                e = exp_q.pop_front();
                check(got == e, cur_tag, "write {bank,addr,data}", got, e);
            end
        end
        if (rst_n && reg_req && !reg_wr && reg_addr == O_STA && track_reads
            && int'(reg_bank) == track_bank) begin
            if (last_read >= 0)
                check(cyc - last_read == GAP + 2, "R9", "status read spacing",
                      cyc - last_read, GAP + 2);
            last_read = cyc;
            sta_reads++;
        end
    end

    // Model of one operation: fills the expected write queue, returns
    // 0 done, 1 timeout, 2 bad target.
    function automatic int predict(input bit fence);
        int res;
        res = 0;
        for (int k = 0; k < STEPS; k++) begin
            int i;
            int b;
            logic [DW-1:0] sta;
            logic [AW-1:0] dofs;
            i = fence ? k : STEPS - 1 - k;
            if (t_mask[i] == '0) begin
                if (fence) break;
                continue;
            end
            if (t_bank[i] > 2'd1) begin res = 2; break; end
            b = int'(t_bank[i][0]);
            dofs = fence ? t_set[i] : t_rel[i];
            if (dofs != '0) begin
                exp_q.push_back({b[0], dofs, t_mask[i]});
                if (dofs == O_SET) mdl_en[b] = mdl_en[b] | t_mask[i];
                else if (dofs == O_REL) mdl_en[b] = mdl_en[b] & ~t_mask[i];
                else if (dofs == O_EN) mdl_en[b] = t_mask[i];
            end else begin
                mdl_en[b] = fence ? (mdl_en[b] | t_mask[i]) : (mdl_en[b] & ~t_mask[i]);
                exp_q.push_back({b[0], t_en[i], mdl_en[b]});
            end
            sta = (mdl_en[b] | hi_f[b]) & ~lo_f[b];
            if (fence ? ((sta & t_mask[i]) != t_mask[i]) : ((sta & t_ack[i]) != '0)) begin
                res = 1;
                break;
            end
        end
        return res;
    endfunction

    task automatic wipe_banks();
        @(negedge clk);
        bank_wipe = 1'b1;
        @(negedge clk);
        bank_wipe = 1'b0;
        mdl_en[0] = '0;
        mdl_en[1] = '0;
    endtask

    // Run one operation and compare its outcome; optionally pulse the
    // opposite command mid-run to show it is ignored.
    task automatic run_op(input bit fence, input bit both, input bit inject, input string tag);
        int exp_res, got_res, n;
        cur_tag = tag;
        exp_res = predict(fence);
        @(negedge clk);
        cmd_fence = fence | both;
        cmd_release = ~fence | both;
        @(negedge clk);
        cmd_fence = 1'b0;
        cmd_release = 1'b0;
        check(busy == 1'b1, "R2", "busy after command", busy, 1);
        n = 0;
        while (!(done || timeout || bad_tgt) && n < 3000) begin
            if (inject && n == 3) begin cmd_release = 1'b1; cmd_fence = 1'b1; end
            else begin cmd_release = 1'b0; cmd_fence = 1'b0; end
            @(negedge clk);
            n++;
        end
        cmd_release = 1'b0;
        cmd_fence = 1'b0;
        got_res = done ? 0 : timeout ? 1 : bad_tgt ? 2 : 3;
        check(got_res == exp_res, tag, "result code (0 done,1 tmo,2 bad)", got_res, exp_res);
        check(!busy, "R10", "busy low with result", busy, 0);
        repeat (6) @(negedge clk);
        check(!busy && !done && !timeout && !bad_tgt, "R2", "quiet after operation",
              {busy, done, timeout, bad_tgt}, 0);
        check(exp_q.size() == 0, tag, "writes outstanding", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic table_main();
        t_bank = {2'd1, 2'd0, 2'd1, 2'd0};
        t_set  = {O_SET, 8'd0, 8'd0, O_SET};
        t_rel  = {8'd0, O_REL, 8'd0, O_REL};
        t_en   = {O_EN, O_EN, O_EN, O_EN};
        t_sta  = {O_STA, O_STA, O_STA, O_STA};
        t_mask = {32'h0000_F000, 32'h0000_0F00, 32'h0000_00F0, 32'h0000_000F};
        t_ack  = t_mask;
    endtask

    initial begin
        hi_f[0] = '0; hi_f[1] = '0; lo_f[0] = '0; lo_f[1] = '0;
        mdl_en[0] = '0; mdl_en[1] = '0;
        bank_en[0] = '0; bank_en[1] = '0;
        table_main();
        repeat (3) @(negedge clk);
        check(!busy && !done && !timeout && !bad_tgt && !reg_req, "R1", "reset outputs",
              {busy, done, timeout, bad_tgt, reg_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !reg_req, "R1", "idle after reset", {busy, reg_req}, 0);

        // R3 R5 R8: forward walk over both banks and both write modes,
        // with a stray command mid-run (R2).
        run_op(1'b1, 1'b0, 1'b1, "R3");
        // R4 R6: reverse walk undoes it.
        run_op(1'b0, 1'b0, 1'b0, "R4");

        // R3: fence stops at the empty step 1; R4: release skips it.
        wipe_banks();
        t_mask[1] = '0;
        run_op(1'b1, 1'b0, 1'b0, "R3");
        run_op(1'b0, 1'b0, 1'b0, "R4");

        // R2: both commands at once picks fence.
        table_main();
        wipe_banks();
        run_op(1'b1, 1'b1, 1'b0, "R2");
        run_op(1'b0, 1'b0, 1'b0, "R6");

        // R8: unknown bank code at step 2 aborts before that step.
        wipe_banks();
        t_bank[2] = 2'd2;
        run_op(1'b1, 1'b0, 1'b0, "R8");
        t_bank[2] = 2'd3;
        wipe_banks();
        run_op(1'b0, 1'b0, 1'b0, "R8");

        // R9: bank 1 never shows bit 4, step 1 times out, step 2 and 3 skipped.
        table_main();
        wipe_banks();
        lo_f[1] = 32'h0000_0010;
        sta_reads = 0; last_read = -1; track_bank = 1; track_reads = 1'b1;
        run_op(1'b1, 1'b0, 1'b0, "R9");
        track_reads = 1'b0;
        check(sta_reads == (TMO - 1 + GAP + 1) / (GAP + 2) + 1, "R9", "status reads before timeout",
              sta_reads, (TMO - 1 + GAP + 1) / (GAP + 2) + 1);
        lo_f[1] = '0;

        // R7: a stuck bit outside the release ack mask does not block.
        wipe_banks();
        run_op(1'b1, 1'b0, 1'b0, "R7");
        hi_f[0] = 32'h0001_0000;
        run_op(1'b0, 1'b0, 1'b0, "R7");
        // R7: the same bit inside step 0's ack mask blocks release.
        run_op(1'b1, 1'b0, 1'b0, "R7");
        t_ack[0] = 32'h0001_000F;
        run_op(1'b0, 1'b0, 1'b0, "R7");
        hi_f[0] = '0;

        // R3: empty table finishes at once with no writes.
        t_mask = '0;
        run_op(1'b1, 1'b0, 1'b0, "R3");
        run_op(1'b0, 1'b0, 1'b0, "R4");

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule